// File: doc/BRIEF.md
# Hash Store/Check Instruction Unit

This unit executes the four return-address protection instructions: a hash store and a hash check, each in a user form and a privileged form. It takes one 32-bit instruction word at a time and decodes it. It reads the two source registers and forms a negative, doubleword-scaled effective address from the base register. It hands the two register values and a selected 64-bit key to an external digest engine. Once the digest is back, a store writes it to memory. A check reads the stored doubleword, compares it with the digest, and raises a trap when the two differ.

The unit holds two 64-bit key registers, one for user forms and one for privileged forms. Both clear on reset and are written through a dedicated key-write port. Only one instruction is in flight at a time. While an instruction is in flight, `busy` is high and new issues are dropped. Each instruction ends with a one-cycle `done` pulse or a one-cycle exception pulse that carries a cause code.

Top module: `hashguard_unit`

## Requirements
- R1: An instruction word is accepted only when bits 31:26 equal 011111 and bits 10:1 equal one of: 1011010010 (user store), 1011110010 (user check), 1010010010 (privileged store) or 1010110010 (privileged check). Any other word is ignored: `busy` stays low and no request, `done` or exception follows.
- R2: The effective address is the value of register RA (index in bits 20:16) plus an offset. The offset has bits 63:9 all ones, bits 8:3 holding the 6-bit field {insn[0], insn[25:21]}, and bits 2:0 zero. This covers −512 (field 0) to −8 (field 63), with 64-bit wraparound.
- R3: The digest request carries the value of RA, the value of RB (index in bits 15:11) and a key. User forms use the user key and privileged forms use the privileged key. Both keys read as zero after reset.
- R4: A store issues one memory write (`mem_we`=1) of the returned digest to the effective address and then pulses `done`.
- R5: A check issues one memory read (`mem_we`=0) at the effective address. If the returned word equals the digest it pulses `done`. Otherwise it pulses `exc_valid` with cause 3 (trap).
- R6: When the RA field is 0, the unit pulses `exc_valid` with cause 1 (illegal form) and issues no digest request and no memory access.
- R7: A privileged form issued with `issue_priv`=0 pulses `exc_valid` with cause 2 (privilege) and issues no digest request and no memory access. This check takes priority over the RA=0 check.
- R8: With `feat_en`=0 at issue, every accepted instruction completes with a `done` pulse and nothing else: no digest request, no memory access and no exception, even when RA is 0.
- R9: `busy` rises the cycle after acceptance and falls in the same cycle that the `done` or exception pulse appears. Issues made while `busy` is high are ignored.
- R10: `done` and `exc_valid` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Instruction offered this cycle |
| issue_insn | input | 32 | Instruction word |
| issue_priv | input | 1 | 1 = issuing context is privileged |
| feat_en | input | 1 | 1 = hash instructions enabled; 0 = execute as no-ops |
| busy | output | 1 | Instruction in flight |
| key_wr_en | input | 1 | Key register write strobe |
| key_wr_sel | input | 1 | 0 = user key, 1 = privileged key |
| key_wr_data | input | 64 | Key write value |
| rf_ra_idx | output | 5 | Register read index A |
| rf_rb_idx | output | 5 | Register read index B |
| rf_ra_val | input | 64 | Register A value (combinational read) |
| rf_rb_val | input | 64 | Register B value (combinational read) |
| dg_req | output | 1 | Digest request, held until `dg_ack` |
| dg_a | output | 64 | Digest operand from RA |
| dg_b | output | 64 | Digest operand from RB |
| dg_key | output | 64 | Digest key |
| dg_ack | input | 1 | Digest result valid |
| dg_result | input | 64 | Digest value |
| mem_req | output | 1 | Memory request, held until `mem_rsp` |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 64 | Effective address |
| mem_wdata | output | 64 | Write data |
| mem_rsp | input | 1 | Memory completion |
| mem_rdata | input | 64 | Read data |
| done | output | 1 | Normal completion pulse |
| exc_valid | output | 1 | Exception pulse |
| exc_cause | output | 2 | 1 illegal form, 2 privilege, 3 trap |

## Verification
The assertions assume that the digest engine and memory raise their acknowledge only while the matching request is high, and keep it for a single cycle. They also assume that the register file answers combinationally for the index the unit drives. The bench models all three at the falling edge. Each acknowledge lasts exactly one cycle and appears only after a request has been seen, and the register array is written only while the unit is idle. Key writes are also made only while the unit is idle, so the key captured for a request is the one the bench expects.

// File: rtl/hashguard_pkg.sv
package hashguard_pkg;
  localparam logic [5:0] PRIMARY_OP = 6'b011111;
  localparam logic [9:0] XO_STORE   = 10'b1011010010;
  localparam logic [9:0] XO_CHECK   = 10'b1011110010;
  localparam logic [9:0] XO_STOREP  = 10'b1010010010;
  localparam logic [9:0] XO_CHECKP  = 10'b1010110010;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_ILLEGAL = 2'd1,
    CAUSE_PRIV    = 2'd2,
    CAUSE_TRAP    = 2'd3
  } cause_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DECODE = 2'd1,
    ST_DIGEST = 2'd2,
    ST_MEM    = 2'd3
  } state_t;

  typedef struct packed {
    logic       hit;
    logic       is_check;
    logic       is_priv;
    logic [4:0] ra;
    logic [4:0] rb;
    logic [5:0] disp;
  } dec_t;
endpackage

// File: rtl/hashguard_decode.sv
module hashguard_decode
  import hashguard_pkg::*;
(
  input  logic [31:0] insn,
  output dec_t        dec
);
  logic [9:0] xo;
  assign xo = insn[10:1];

  always_comb begin
    dec          = '0;
    dec.ra       = insn[20:16];
    dec.rb       = insn[15:11];
    dec.disp     = {insn[0], insn[25:21]};
    if (insn[31:26] == PRIMARY_OP) begin
      unique case (xo)
        XO_STORE:  begin dec.hit = 1'b1; end
        XO_CHECK:  begin dec.hit = 1'b1; dec.is_check = 1'b1; end
        XO_STOREP: begin dec.hit = 1'b1; dec.is_priv = 1'b1; end
        XO_CHECKP: begin dec.hit = 1'b1; dec.is_check = 1'b1; dec.is_priv = 1'b1; end
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/hashguard_keybank.sv
module hashguard_keybank #(
  parameter int KEY_W = 64,
  parameter int NUM_KEYS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [KEY_W-1:0] wr_data,
  input  logic             rd_sel,
  output logic [KEY_W-1:0] rd_key
);
  logic [KEY_W-1:0] keys [NUM_KEYS];

  for (genvar g = 0; g < NUM_KEYS; g++) begin : g_key
    always_ff @(posedge clk) begin
      if (rst) begin
        keys[g] <= '0;
      end else if (wr_en && (int'(wr_sel) == g)) begin
        keys[g] <= wr_data;
      end
    end
  end

  assign rd_key = keys[int'(rd_sel)];
endmodule

// File: rtl/hashguard_addrgen.sv
module hashguard_addrgen #(
  parameter int ADDR_W = 64,
  parameter int DISP_W = 6,
  parameter int SCALE_SH = 3
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] ea
);
  localparam int ONES_W = ADDR_W - DISP_W - SCALE_SH;
  logic [ADDR_W-1:0] offset;

  assign offset = {{ONES_W{1'b1}}, disp, {SCALE_SH{1'b0}}};
  assign ea     = base + offset;
endmodule

// File: rtl/hashguard_unit.sv
module hashguard_unit
  import hashguard_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_valid,
  input  logic [31:0]       issue_insn,
  input  logic              issue_priv,
  input  logic              feat_en,
  output logic              busy,
  input  logic              key_wr_en,
  input  logic              key_wr_sel,
  input  logic [DATA_W-1:0] key_wr_data,
  output logic [IDX_W-1:0]  rf_ra_idx,
  output logic [IDX_W-1:0]  rf_rb_idx,
  input  logic [DATA_W-1:0] rf_ra_val,
  input  logic [DATA_W-1:0] rf_rb_val,
  output logic              dg_req,
  output logic [DATA_W-1:0] dg_a,
  output logic [DATA_W-1:0] dg_b,
  output logic [DATA_W-1:0] dg_key,
  input  logic              dg_ack,
  input  logic [DATA_W-1:0] dg_result,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rsp,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              exc_valid,
  output logic [1:0]        exc_cause
);
  localparam int DISP_W = 6;

  state_t            state;
  dec_t              dec_in;
  logic              is_check_q;
  logic              is_priv_q;
  logic              priv_mode_q;
  logic              feat_q;
  logic [DISP_W-1:0] disp_q;
  logic [DATA_W-1:0] digest_q;
  logic [DATA_W-1:0] sel_key;
  logic [DATA_W-1:0] ea;

  hashguard_decode u_decode (
    .insn (issue_insn),
    .dec  (dec_in)
  );

  hashguard_keybank #(.KEY_W(DATA_W), .NUM_KEYS(2)) u_keys (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (key_wr_en),
    .wr_sel  (key_wr_sel),
    .wr_data (key_wr_data),
    .rd_sel  (is_priv_q),
    .rd_key  (sel_key)
  );

  hashguard_addrgen #(.ADDR_W(DATA_W), .DISP_W(DISP_W), .SCALE_SH(3)) u_addr (
    .base (rf_ra_val),
    .disp (disp_q),
    .ea   (ea)
  );

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      is_check_q  <= 1'b0;
      is_priv_q   <= 1'b0;
      priv_mode_q <= 1'b0;
      feat_q      <= 1'b0;
      disp_q      <= '0;
      digest_q    <= '0;
      rf_ra_idx   <= '0;
      rf_rb_idx   <= '0;
      dg_req      <= 1'b0;
      dg_a        <= '0;
      dg_b        <= '0;
      dg_key      <= '0;
      mem_req     <= 1'b0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      done        <= 1'b0;
      exc_valid   <= 1'b0;
      exc_cause   <= CAUSE_NONE;
    end else begin
      done      <= 1'b0;
      exc_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (issue_valid && dec_in.hit) begin
            is_check_q  <= dec_in.is_check;
            is_priv_q   <= dec_in.is_priv;
            priv_mode_q <= issue_priv;
            feat_q      <= feat_en;
            disp_q      <= dec_in.disp;
            rf_ra_idx   <= dec_in.ra;
            rf_rb_idx   <= dec_in.rb;
            state       <= ST_DECODE;
          end
        end
        ST_DECODE: begin
          if (!feat_q) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else if (is_priv_q && !priv_mode_q) begin
            exc_valid <= 1'b1;
            exc_cause <= CAUSE_PRIV;
            state     <= ST_IDLE;
          end else if (rf_ra_idx == '0) begin
            exc_valid <= 1'b1;
            exc_cause <= CAUSE_ILLEGAL;
            state     <= ST_IDLE;
          end else begin
            dg_req   <= 1'b1;
            dg_a     <= rf_ra_val;
            dg_b     <= rf_rb_val;
            dg_key   <= sel_key;
            mem_addr <= ea;
            state    <= ST_DIGEST;
          end
        end
        ST_DIGEST: begin
          if (dg_ack) begin
            dg_req   <= 1'b0;
            digest_q <= dg_result;
            mem_req  <= 1'b1;
            mem_we   <= !is_check_q;
            if (!is_check_q) begin
              mem_wdata <= dg_result;
            end
            state <= ST_MEM;
          end
        end
        ST_MEM: begin
          if (mem_rsp) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            if (is_check_q && (mem_rdata != digest_q)) begin
              exc_valid <= 1'b1;
              exc_cause <= CAUSE_TRAP;
            end else begin
              done <= 1'b1;
            end
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hashguard_unit_chk.sv
module hashguard_unit_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              dg_req,
  input logic              dg_ack,
  input logic [DATA_W-1:0] dg_key,
  input logic              mem_req,
  input logic              mem_rsp,
  input logic [DATA_W-1:0] mem_addr,
  input logic              done,
  input logic              exc_valid,
  input logic [1:0]        exc_cause
);
  p_pulse_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(done && exc_valid));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_exc_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    exc_valid |=> !exc_valid);

  p_exc_cause_r6: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> (exc_cause != 2'd0));

  p_busy_end_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done || exc_valid));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_req && !dg_req));

  p_mem_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rsp) |=> (mem_req && $stable(mem_addr)));

  p_dg_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (dg_req && !dg_ack) |=> (dg_req && $stable(dg_key)));
endmodule

bind hashguard_unit hashguard_unit_chk #(.DATA_W(DATA_W)) i_hashguard_unit_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .dg_req    (dg_req),
  .dg_ack    (dg_ack),
  .dg_key    (dg_key),
  .mem_req   (mem_req),
  .mem_rsp   (mem_rsp),
  .mem_addr  (mem_addr),
  .done      (done),
  .exc_valid (exc_valid),
  .exc_cause (exc_cause)
);

// File: tb/test_hashguard_unit.sv
`timescale 1ns/1ps
module test_hashguard_unit;
  localparam logic [9:0] XS  = 10'b1011010010;
  localparam logic [9:0] XC  = 10'b1011110010;
  localparam logic [9:0] XSP = 10'b1010010010;
  localparam logic [9:0] XCP = 10'b1010110010;
  localparam int DG_LAT = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_valid = 1'b0;
  logic [31:0] issue_insn = '0;
  logic        issue_priv = 1'b0;
  logic        feat_en = 1'b1;
  logic        busy;
  logic        key_wr_en = 1'b0;
  logic        key_wr_sel = 1'b0;
  logic [63:0] key_wr_data = '0;
  logic [4:0]  rf_ra_idx, rf_rb_idx;
  logic [63:0] rf_ra_val, rf_rb_val;
  logic        dg_req;
  logic [63:0] dg_a, dg_b, dg_key;
  logic        dg_ack = 1'b0;
  logic [63:0] dg_result = '0;
  logic        mem_req, mem_we;
  logic [63:0] mem_addr, mem_wdata;
  logic        mem_rsp = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic        done, exc_valid;
  logic [1:0]  exc_cause;

  logic [63:0] regs [32];
  logic [63:0] rd_word = '0;
  int          dg_cnt = 0, st_cnt = 0, rd_cnt = 0, dg_wait = 0;
  logic [63:0] last_dg_a, last_dg_b, last_dg_key, last_st_addr, last_st_data, last_rd_addr;
  int          errors = 0, checks = 0;
  logic        finished = 1'b0;

  always #2.5 clk = ~clk;

  assign rf_ra_val = regs[rf_ra_idx];
  assign rf_rb_val = regs[rf_rb_idx];

  hashguard_unit i_hashguard_unit (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_insn(issue_insn),
    .issue_priv(issue_priv), .feat_en(feat_en), .busy(busy),
    .key_wr_en(key_wr_en), .key_wr_sel(key_wr_sel), .key_wr_data(key_wr_data),
    .rf_ra_idx(rf_ra_idx), .rf_rb_idx(rf_rb_idx), .rf_ra_val(rf_ra_val), .rf_rb_val(rf_rb_val),
    .dg_req(dg_req), .dg_a(dg_a), .dg_b(dg_b), .dg_key(dg_key), .dg_ack(dg_ack), .dg_result(dg_result),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rsp(mem_rsp), .mem_rdata(mem_rdata),
    .done(done), .exc_valid(exc_valid), .exc_cause(exc_cause)
  );

  function automatic logic [63:0] dig(input logic [63:0] a, input logic [63:0] b, input logic [63:0] k);
    return a ^ {b[18:0], b[63:19]} ^ (k * 64'd3 + 64'h5A5A_0F0F_C3C3_9696);
  endfunction

  function automatic logic [31:0] mk(input logic [9:0] xo, input logic [5:0] d,
                                     input logic [4:0] ra, input logic [4:0] rb);
    return {6'b011111, d[4:0], ra, rb, xo, d[5]};
  endfunction

  function automatic logic [63:0] off(input logic [5:0] d);
    return 64'hFFFF_FFFF_FFFF_FE00 | ({58'd0, d} << 3);
  endfunction

  // digest engine and memory models, driven at the falling edge
  always @(negedge clk) begin
    if (dg_req && !dg_ack) begin
      if (dg_wait == DG_LAT) begin
        dg_ack      <= 1'b1;
        dg_result   <= dig(dg_a, dg_b, dg_key);
        last_dg_a   <= dg_a;
        last_dg_b   <= dg_b;
        last_dg_key <= dg_key;
        dg_cnt      <= dg_cnt + 1;
        dg_wait     <= 0;
      end else begin
        dg_wait <= dg_wait + 1;
      end
    end else begin
      dg_ack <= 1'b0;
    end
    if (mem_req && !mem_rsp) begin
      mem_rsp <= 1'b1;
      if (mem_we) begin
        st_cnt       <= st_cnt + 1;
        last_st_addr <= mem_addr;
        last_st_data <= mem_wdata;
      end else begin
        rd_cnt       <= rd_cnt + 1;
        last_rd_addr <= mem_addr;
        mem_rdata    <= rd_word;
      end
    end else begin
      mem_rsp <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_key(input logic sel, input logic [63:0] v);
    @(negedge clk);
    key_wr_en = 1'b1; key_wr_sel = sel; key_wr_data = v;
    @(negedge clk);
    key_wr_en = 1'b0;
  endtask

  // issue one word and wait for completion; returns 0 none, 1 done, 2 exception
  task automatic run_op(input logic [31:0] w, input logic pv, input logic fe,
                        output int outcome, output logic [1:0] cause);
    outcome = 0; cause = 0;
    @(negedge clk);
    issue_valid = 1'b1; issue_insn = w; issue_priv = pv; feat_en = fe;
    @(negedge clk);
    issue_valid = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (done) begin outcome = 1; break; end
      if (exc_valid) begin outcome = 2; cause = exc_cause; break; end
      @(negedge clk);
    end
    chk(!busy, "R9 busy low at end", 64'(busy), 64'd0);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !exc_valid, "R9 reset idle", 64'(busy), 64'd0);
    chk(!mem_req && !dg_req, "R10 reset no requests", 64'(mem_req), 64'd0);
  endtask

  task automatic t_store_reset_key;
    int o; logic [1:0] c; int s0;
    regs[5] = 64'h0000_7FFF_0000_1000; regs[7] = 64'h1234_5678_9ABC_DEF0;
    s0 = st_cnt;
    run_op(mk(XS, 6'd63, 5'd5, 5'd7), 1'b0, 1'b1, o, c);
    chk(o == 1, "R4 store done", 64'(o), 64'd1);
    chk(last_dg_key == 64'd0, "R3 user key resets to zero", last_dg_key, 64'd0);
    chk(last_dg_a == regs[5] && last_dg_b == regs[7], "R3 operands", last_dg_b, regs[7]);
    chk(st_cnt == s0 + 1, "R4 one write", 64'(st_cnt - s0), 64'd1);
    chk(last_st_addr == regs[5] - 64'd8, "R2 field 63 gives -8", last_st_addr, regs[5] - 64'd8);
    chk(last_st_data == dig(regs[5], regs[7], 64'd0), "R4 store data", last_st_data,
        dig(regs[5], regs[7], 64'd0));
  endtask

  task automatic t_store_keys;
    int o; logic [1:0] c; logic [63:0] e;
    write_key(1'b0, 64'hAAAA_1111_2222_3333);
    write_key(1'b1, 64'h5555_9999_8888_7777);
    regs[3] = 64'h0000_0000_0000_0100; regs[9] = 64'hDEAD_BEEF_0000_0001;
    run_op(mk(XS, 6'd0, 5'd3, 5'd9), 1'b1, 1'b1, o, c);
    chk(last_dg_key == 64'hAAAA_1111_2222_3333, "R3 user form uses user key", last_dg_key,
        64'hAAAA_1111_2222_3333);
    e = 64'h0000_0000_0000_0100 + 64'hFFFF_FFFF_FFFF_FE00;
    chk(last_st_addr == e, "R2 field 0 gives -512 with wrap", last_st_addr, e);
    regs[4] = 64'h0000_4000_0000_0000;
    run_op(mk(XSP, 6'd42, 5'd4, 5'd9), 1'b1, 1'b1, o, c);
    chk(o == 1, "R4 privileged store done", 64'(o), 64'd1);
    chk(last_dg_key == 64'h5555_9999_8888_7777, "R3 privileged key", last_dg_key,
        64'h5555_9999_8888_7777);
    e = regs[4] + off(6'd42);
    chk(last_st_addr == e, "R2 split field 42", last_st_addr, e);
  endtask

  task automatic t_check;
    int o; logic [1:0] c; int r0;
    regs[6] = 64'h0000_0000_8000_0000; regs[8] = 64'h0F0F_0F0F_F0F0_F0F0;
    rd_word = dig(regs[6], regs[8], 64'hAAAA_1111_2222_3333);
    r0 = rd_cnt;
    run_op(mk(XC, 6'd17, 5'd6, 5'd8), 1'b0, 1'b1, o, c);
    chk(o == 1, "R5 matching check done", 64'(o), 64'd1);
    chk(rd_cnt == r0 + 1, "R5 one read", 64'(rd_cnt - r0), 64'd1);
    chk(last_rd_addr == regs[6] + off(6'd17), "R5 read address", last_rd_addr, regs[6] + off(6'd17));
    rd_word = dig(regs[6], regs[8], 64'h5555_9999_8888_7777) ^ 64'd1;
    run_op(mk(XCP, 6'd5, 5'd6, 5'd8), 1'b1, 1'b1, o, c);
    chk(o == 2 && c == 2'd3, "R5 mismatch traps", {62'd0, c}, 64'd3);
  endtask

  task automatic t_faults;
    int o; logic [1:0] c; int d0, s0, r0;
    d0 = dg_cnt; s0 = st_cnt; r0 = rd_cnt;
    run_op(mk(XS, 6'd1, 5'd0, 5'd2), 1'b0, 1'b1, o, c);
    chk(o == 2 && c == 2'd1, "R6 RA zero illegal", {62'd0, c}, 64'd1);
    run_op(mk(XCP, 6'd1, 5'd0, 5'd2), 1'b0, 1'b1, o, c);
    chk(o == 2 && c == 2'd2, "R7 privilege before RA zero", {62'd0, c}, 64'd2);
    run_op(mk(XSP, 6'd1, 5'd5, 5'd2), 1'b0, 1'b1, o, c);
    chk(o == 2 && c == 2'd2, "R7 privileged in user mode", {62'd0, c}, 64'd2);
    chk(dg_cnt == d0 && st_cnt == s0 && rd_cnt == r0, "R6 R7 no digest or memory",
        64'(dg_cnt - d0 + st_cnt - s0 + rd_cnt - r0), 64'd0);
  endtask

  task automatic t_feature_off;
    int o; logic [1:0] c; int d0, s0, r0;
    d0 = dg_cnt; s0 = st_cnt; r0 = rd_cnt;
    run_op(mk(XC, 6'd3, 5'd0, 5'd2), 1'b0, 1'b0, o, c);
    chk(o == 1, "R8 no-op done even with RA zero", 64'(o), 64'd1);
    run_op(mk(XSP, 6'd3, 5'd5, 5'd2), 1'b0, 1'b0, o, c);
    chk(o == 1, "R8 privileged no-op done", 64'(o), 64'd1);
    chk(dg_cnt == d0 && st_cnt == s0 && rd_cnt == r0, "R8 no side effects",
        64'(dg_cnt - d0 + st_cnt - s0 + rd_cnt - r0), 64'd0);
  endtask

  task automatic t_ignore;
    int d0; bit seen;
    d0 = dg_cnt; seen = 0;
    @(negedge clk);
    issue_valid = 1'b1; issue_insn = mk(10'b1011010011, 6'd1, 5'd5, 5'd7); feat_en = 1'b1;
    @(negedge clk);
    issue_insn = {6'b011110, 5'd1, 5'd5, 5'd7, XS, 1'b0};
    @(negedge clk);
    issue_valid = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (busy || done || exc_valid || mem_req || dg_req) seen = 1;
      @(negedge clk);
    end
    chk(!seen && dg_cnt == d0, "R1 foreign words ignored", 64'(seen), 64'd0);
  endtask

  task automatic t_busy_issue;
    int s0; logic [63:0] e;
    s0 = st_cnt;
    regs[10] = 64'h0000_0000_0002_0000; regs[11] = 64'h77;
    @(negedge clk);
    issue_valid = 1'b1; issue_insn = mk(XS, 6'd10, 5'd10, 5'd11); issue_priv = 1'b0; feat_en = 1'b1;
    @(negedge clk);
    chk(busy, "R9 busy after accept", 64'(busy), 64'd1);
    issue_insn = mk(XS, 6'd20, 5'd5, 5'd11);
    @(negedge clk);
    issue_valid = 1'b0;
    for (int i = 0; i < 30; i++) @(negedge clk);
    e = regs[10] + off(6'd10);
    chk(st_cnt == s0 + 1, "R9 issue while busy dropped", 64'(st_cnt - s0), 64'd1);
    chk(last_st_addr == e, "R9 first instruction wins", last_st_addr, e);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) regs[i] = 64'(i) * 64'h0101_0101;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_store_reset_key();
    t_store_keys();
    t_check();
    t_faults();
    t_feature_off();
    t_ignore();
    t_busy_issue();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(5ns * 100000);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule